// File: doc/BRIEF.md
# Oversampled Type B Frame Receiver

This block recovers reader-to-card Type B frames from a single demodulated bit stream. The stream is delivered as samples, four per bit period. Each sample comes with an enable strobe, so the sample rate can be any fraction of the clock rate. The receiver locks onto the long low start-of-frame and qualifies its length. It then assembles ten-bit characters, least significant bit first, each framed by a low start bit and a high stop bit. For every good character it presents one data byte with a running byte count. It finishes the frame on a character that is low for all ten bits.

Timing faults end the frame attempt and pulse an error flag. These faults are a start-of-frame that is too short or too long, an idle gap between characters that is too long, a malformed character, or a frame that reaches the configured byte limit. After an error the receiver waits for a run of idle-high samples before it looks for a new frame. Later stages handle CRC checking and command decoding on the byte stream.

Top module: `tbr_rx`

## Requirements
- R1: A bit's value is the sample at phase 2 of its four-sample period. Phase 0 is the sample on which the falling edge (start-of-frame or start bit) was seen, and the phase advances by one on every enabled sample.
- R2: While unsynchronised, a low sample starts start-of-frame measurement. The start-of-frame is accepted when the line is sampled high after 10, 11 or 12 low bits.
- R3: A start-of-frame whose line is sampled high after 9 or fewer low bits, or that reaches 13 low bits, pulses `frame_err` for one cycle.
- R4: Between characters, the 26th consecutive high sample without a start edge pulses `frame_err`. A start edge after 25 high samples is still accepted. Samples remaining in the previous stop bit after it is judged are counted.
- R5: A character whose first bit is 0 and tenth bit is 1 is data. Its bits 2 to 9 form `byte_data`, with bit 2 as the LSB. The byte is shown with a one-cycle `byte_vld`, and `byte_cnt` rises by one in the same cycle.
- R6: A character with all ten bits 0 ends the frame with a one-cycle `frame_done`. `byte_cnt` then holds the number of data bytes in the frame.
- R7: A character that is neither data nor end-of-frame pulses `frame_err`. This includes a stop bit of 0 with nonzero content, or a start bit sampled 1.
- R8: When the byte count reaches `MAX_BYTES`, that byte is still shown, `frame_err` pulses in the same cycle, and no `frame_done` follows.
- R9: After any error, input is ignored until 11 consecutive high samples have been seen. A low sample restarts that count. A frame sent before then produces no byte and no `frame_done`.
- R10: Reset or a synchronous `clr` sets `byte_cnt` to 0, clears all pulses and returns the receiver to the unsynchronised state.
- R11: A cycle with `smp_en` low changes no state, whatever `smp_bit` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of state and byte count |
| smp_en | input | 1 | Qualifies `smp_bit` as one sample |
| smp_bit | input | 1 | Demodulated line sample |
| byte_vld | output | 1 | One-cycle pulse with a received data byte |
| byte_data | output | 8 | Received data byte |
| byte_cnt | output | CNT_W | Data bytes received in the current frame |
| frame_done | output | 1 | One-cycle pulse on a valid end-of-frame |
| frame_err | output | 1 | One-cycle pulse when a frame attempt fails |

## Verification
A wrong sampling phase or bit count shows up within one character, which is 40 samples: `byte_data` is shifted or the character is wrongly judged as bad. A timer or hold-off counter that is off by one moves the boundary between an accepted frame and an error by a single sample. So the bench sweeps start-of-frame lengths, gap lengths and hold-off lengths on both sides of each limit. A byte counter that drifts is visible in `byte_cnt` at the next `byte_vld` or at `frame_done`. A stuck state shows up as a missing `frame_done` at the end of the next well-formed frame.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

    localparam int SAMPLES_PER_BIT = 4;
    localparam int PH_W            = $clog2(SAMPLES_PER_BIT);
    localparam int CHAR_BITS       = 10;

    typedef enum logic [2:0] {
        ST_IDLE,   // unsynchronised, waiting for a low sample
        ST_SOF,    // measuring the low part of start-of-frame
        ST_GAP,    // waiting for a start bit edge
        ST_DATA,   // collecting one ten-bit character
        ST_HOLD    // error hold-off
    } rx_state_e;

    typedef enum logic [1:0] {
        CH_DATA,
        CH_EOF,
        CH_BAD
    } char_kind_e;

    // word[0] is the first bit received, word[CHAR_BITS-1] the last
    function automatic char_kind_e classify(input logic [CHAR_BITS-1:0] word);
        if (word == '0)
            return CH_EOF;
        else if (!word[0] && word[CHAR_BITS-1])
            return CH_DATA;
        else
            return CH_BAD;
    endfunction

endpackage

// File: rtl/tbr_char_shift.sv
module tbr_char_shift
    import tbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic [CHAR_BITS-1:0] word
);

    // new bits enter at the top, so the first bit ends up in word[0]
    always_ff @(posedge clk) begin
        if (rst || clear)
            word <= '0;
        else if (shift_en)
            word <= {bit_in, word[CHAR_BITS-1:1]};
    end

endmodule

// File: rtl/tbr_byte_count.sv
module tbr_byte_count #(
    parameter int MAX_BYTES = 64,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             last_slot
);

    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MAX_BYTES - 1);
    localparam logic [CNT_W-1:0] MAX_V  = CNT_W'(MAX_BYTES);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + CNT_W'(1);
    end

    assign last_slot = (cnt == LAST_V);

    // R8: the count never passes the configured limit
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= MAX_V);

    // R8: an increment is never requested once the limit is reached
    assert_no_inc_past_max_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAX_V && !clr) |-> !inc);

endmodule

// File: rtl/tbr_rx.sv
module tbr_rx
    import tbr_pkg::*;
#(
    parameter int MAX_BYTES    = 64,
    parameter int SOF_MIN_BITS = 10,
    parameter int SOF_MAX_BITS = 12,
    parameter int GAP_MAX      = 25,
    parameter int HOLD_MIN     = 10,
    localparam int CNT_W       = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             smp_en,
    input  logic             smp_bit,
    output logic             byte_vld,
    output logic [7:0]       byte_data,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             frame_done,
    output logic             frame_err
);

    localparam int NB_MAX = (SOF_MAX_BITS > CHAR_BITS) ? SOF_MAX_BITS : CHAR_BITS;
    localparam int NB_W   = $clog2(NB_MAX + 2);
    localparam int TM_MAX = (GAP_MAX > HOLD_MIN) ? GAP_MAX : HOLD_MIN;
    localparam int TM_W   = $clog2(TM_MAX + 2);

    localparam logic [PH_W-1:0] PH_MID   = PH_W'(SAMPLES_PER_BIT / 2);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(SAMPLES_PER_BIT - 1);
    localparam logic [NB_W-1:0] SOF_MIN_V = NB_W'(SOF_MIN_BITS);
    localparam logic [NB_W-1:0] SOF_MAX_V = NB_W'(SOF_MAX_BITS);
    localparam logic [NB_W-1:0] CHAR_V    = NB_W'(CHAR_BITS);
    localparam logic [TM_W-1:0] GAP_V     = TM_W'(GAP_MAX);
    localparam logic [TM_W-1:0] HOLD_V    = TM_W'(HOLD_MIN);

    rx_state_e        st, st_n;
    logic [PH_W-1:0]  ph, ph_n, ph_inc;
    logic [NB_W-1:0]  nbit, nbit_n, nbit_inc;
    logic [TM_W-1:0]  tmr, tmr_n, tmr_inc;
    logic             cnt_clr, cnt_inc, last_slot;
    logic             sh_clr, sh_en;
    logic [CHAR_BITS-1:0] word;
    logic             vld_n, done_n, err_n, fail;

    tbr_char_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (sh_clr),
        .shift_en (sh_en),
        .bit_in   (smp_bit),
        .word     (word)
    );

    tbr_byte_count #(
        .MAX_BYTES (MAX_BYTES),
        .CNT_W     (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst       (rst),
        .clr       (cnt_clr),
        .inc       (cnt_inc),
        .cnt       (byte_cnt),
        .last_slot (last_slot)
    );

    assign ph_inc   = ph + PH_W'(1);
    assign nbit_inc = nbit + NB_W'(1);
    assign tmr_inc  = tmr + TM_W'(1);

    always_comb begin
        st_n    = st;
        ph_n    = ph;
        nbit_n  = nbit;
        tmr_n   = tmr;
        cnt_clr = clr;
        cnt_inc = 1'b0;
        sh_clr  = 1'b0;
        sh_en   = 1'b0;
        vld_n   = 1'b0;
        done_n  = 1'b0;
        fail    = 1'b0;
        if (clr) begin
            st_n = ST_IDLE;
        end else if (smp_en) begin
            unique case (st)
                ST_IDLE: begin
                    if (!smp_bit) begin
                        st_n    = ST_SOF;
                        ph_n    = '0;
                        nbit_n  = '0;
                        cnt_clr = 1'b1;
                    end
                end
                ST_SOF: begin
                    ph_n = ph_inc;
                    if (ph_inc == PH_MID) begin
                        if (smp_bit) begin
                            if (nbit >= SOF_MIN_V) begin
                                st_n  = ST_GAP;
                                tmr_n = '0;
                            end else begin
                                fail = 1'b1;
                            end
                        end else if (nbit_inc > SOF_MAX_V) begin
                            fail = 1'b1;
                        end else begin
                            nbit_n = nbit_inc;
                        end
                    end
                end
                ST_GAP: begin
                    if (!smp_bit) begin
                        st_n   = ST_DATA;
                        ph_n   = '0;
                        nbit_n = '0;
                        sh_clr = 1'b1;
                    end else if (tmr_inc > GAP_V) begin
                        fail = 1'b1;
                    end else begin
                        tmr_n = tmr_inc;
                    end
                end
                ST_DATA: begin
                    ph_n = ph_inc;
                    if (ph_inc == PH_MID) begin
                        sh_en  = 1'b1;
                        nbit_n = nbit_inc;
                    end
                    if (ph_inc == PH_LAST && nbit == CHAR_V) begin
                        unique case (classify(word))
                            CH_DATA: begin
                                cnt_inc = 1'b1;
                                vld_n   = 1'b1;
                                if (last_slot) begin
                                    fail = 1'b1;
                                end else begin
                                    st_n  = ST_GAP;
                                    tmr_n = '0;
                                end
                            end
                            CH_EOF: begin
                                done_n = 1'b1;
                                st_n   = ST_IDLE;
                            end
                            default: fail = 1'b1;
                        endcase
                    end
                end
                ST_HOLD: begin
                    if (!smp_bit)
                        tmr_n = '0;
                    else if (tmr_inc > HOLD_V)
                        st_n = ST_IDLE;
                    else
                        tmr_n = tmr_inc;
                end
                default: st_n = ST_IDLE;
            endcase
        end
        err_n = fail;
        if (fail) begin
            st_n  = ST_HOLD;
            tmr_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            ph         <= '0;
            nbit       <= '0;
            tmr        <= '0;
            byte_vld   <= 1'b0;
            byte_data  <= '0;
            frame_done <= 1'b0;
            frame_err  <= 1'b0;
        end else begin
            st         <= st_n;
            ph         <= ph_n;
            nbit       <= nbit_n;
            tmr        <= tmr_n;
            byte_vld   <= vld_n;
            frame_done <= done_n;
            frame_err  <= err_n;
            if (vld_n)
                byte_data <= word[8:1];
        end
    end

    // R2: start-of-frame is left for the gap state only on a high sample
    assert_sof_exit_high_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP && $past(st) == ST_SOF) |-> $past(smp_en && smp_bit));

    // R5: every data byte advances the count by exactly one
    assert_byte_step_R5: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> byte_cnt == $past(byte_cnt) + CNT_W'(1));

    // R6: end-of-frame keeps the count and is not mixed with other pulses
    assert_done_keeps_cnt_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (byte_cnt == $past(byte_cnt) && !frame_err && !byte_vld));

    // R9: hold-off ends only on a high sample
    assert_hold_exit_high_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_HOLD && st == ST_IDLE && !$past(clr)) |-> $past(smp_en && smp_bit));

    // R10: clear returns to idle with a zero count
    assert_clr_idle_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (st == ST_IDLE && byte_cnt == '0));

    // R11: no enable, no movement
    assert_no_en_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (!smp_en && !clr) |=> ($stable(st) && $stable(byte_cnt) && !byte_vld && !frame_err));

endmodule

// File: tb/tbr_rx_tb.sv
module tbr_rx_tb;

    localparam int MAXB  = 4;
    localparam int CNT_W = $clog2(MAXB + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic             rst = 1'b1;
    logic             clr = 1'b0;
    logic             smp_en = 1'b0;
    logic             smp_bit = 1'b1;
    logic             byte_vld;
    logic [7:0]       byte_data;
    logic [CNT_W-1:0] byte_cnt;
    logic             frame_done;
    logic             frame_err;

    tbr_rx #(.MAX_BYTES(MAXB)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .smp_en     (smp_en),
        .smp_bit    (smp_bit),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .byte_cnt   (byte_cnt),
        .frame_done (frame_done),
        .frame_err  (frame_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit stretch = 1'b0;

    logic [7:0] log_b [0:15];
    int nb = 0, ndone = 0, nerr = 0, last_len = -1;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (byte_vld) begin
                if (nb < 16) log_b[nb] = byte_data;
                nb++;
            end
            if (frame_done) begin
                ndone++;
                last_len = int'(byte_cnt);
            end
            if (frame_err) nerr++;
        end
    end

    always @(posedge clk) begin
        if (cyc > 180000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<180000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic raw(input logic b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_en  = 1'b1;
            smp_bit = b;
            if (stretch) begin
                @(negedge clk);
                smp_en  = 1'b0;
                smp_bit = ~b;
            end
        end
    endtask

    task automatic pause(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_en  = 1'b0;
            smp_bit = 1'b1;
        end
    endtask

    task automatic clear_log();
        nb = 0; ndone = 0; nerr = 0; last_len = -1;
    endtask

    task automatic sof(input int nbits);
        raw(1'b0, 4 * nbits);
        raw(1'b1, 8);
    endtask

    task automatic chr(input logic [7:0] v);
        raw(1'b0, 4);
        for (int i = 0; i < 8; i++) raw(v[i], 4);
        raw(1'b1, 4);
    endtask

    task automatic eof();
        raw(1'b0, 40);
        raw(1'b1, 60);
        pause(2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        chk("R10 reset byte_vld", int'(byte_vld), 0);
        chk("R10 reset frame_done", int'(frame_done), 0);
        chk("R10 reset frame_err", int'(frame_err), 0);
        chk("R10 reset byte_cnt", int'(byte_cnt), 0);

        // R1 R5 R6: every byte value in a one-byte frame
        for (int v = 0; v < 256; v++) begin
            clear_log();
            sof(10);
            chr(8'(v));
            eof();
            chk("R5 byte value", (nb == 1) ? int'(log_b[0]) : -1, v);
            chk("R6 frame length", last_len, 1);
        end

        // R5 R6: several bytes, order kept
        clear_log();
        sof(11);
        chr(8'h12); chr(8'hEF); chr(8'h80);
        eof();
        chk("R5 multi count", nb, 3);
        chk("R5 multi b0", int'(log_b[0]), 'h12);
        chk("R5 multi b1", int'(log_b[1]), 'hEF);
        chk("R5 multi b2", int'(log_b[2]), 'h80);
        chk("R6 multi len", last_len, 3);
        chk("R6 multi done", ndone, 1);

        // R2 R3: start-of-frame length sweep
        for (int n = 6; n <= 14; n++) begin
            bit good;
            good = (n >= 10 && n <= 12);
            clear_log();
            sof(n);
            chr(8'h55);
            eof();
            if (good) begin
                chk("R2 sof accepted done", ndone, 1);
                chk("R2 sof accepted err", nerr, 0);
            end else begin
                chk("R3 sof rejected done", ndone, 0);
                chk("R3 sof rejected err", nerr, 1);
                chk("R3 sof rejected bytes", nb, 0);
            end
        end

        // R4: gap between characters at and past the limit
        for (int g = 24; g <= 27; g++) begin
            clear_log();
            sof(10);
            chr(8'h55);
            raw(1'b1, g);
            chr(8'hAA);
            eof();
            if (g <= 25) begin
                chk("R4 gap ok bytes", nb, 2);
                chk("R4 gap ok done", ndone, 1);
            end else begin
                chk("R4 gap timeout bytes", nb, 1);
                chk("R4 gap timeout err", nerr, 1);
                chk("R4 gap timeout done", ndone, 0);
            end
        end

        // R7: zero stop bit with nonzero content
        clear_log();
        sof(10);
        raw(1'b0, 4);
        for (int i = 0; i < 8; i++) raw(((8'h11 >> i) & 8'h01) != 0, 4);
        raw(1'b0, 4);
        eof();
        chk("R7 bad stop err", nerr, 1);
        chk("R7 bad stop bytes", nb, 0);
        chk("R7 bad stop done", ndone, 0);

        // R7: start bit sampled high
        clear_log();
        sof(10);
        raw(1'b0, 1);
        raw(1'b1, 39);
        raw(1'b1, 60);
        pause(2);
        chk("R7 bad start err", nerr, 1);
        chk("R7 bad start bytes", nb, 0);

        // R8: frame reaching the byte limit
        clear_log();
        sof(10);
        for (int i = 0; i < MAXB; i++) chr(8'(8'h30 + i));
        eof();
        chk("R8 limit bytes", nb, MAXB);
        chk("R8 limit last byte", int'(log_b[MAXB-1]), 'h30 + MAXB - 1);
        chk("R8 limit err", nerr, 1);
        chk("R8 limit done", ndone, 0);

        clear_log();
        sof(10);
        for (int i = 0; i < MAXB - 1; i++) chr(8'(8'h40 + i));
        eof();
        chk("R8 below limit done", ndone, 1);
        chk("R8 below limit len", last_len, MAXB - 1);
        chk("R8 below limit err", nerr, 0);

        // R9: hold-off needs 11 high samples
        for (int h = 10; h <= 11; h++) begin
            clear_log();
            raw(1'b0, 20);
            raw(1'b1, 3 + h);
            sof(10);
            chr(8'h55);
            eof();
            chk("R9 holdoff err", nerr, 1);
            if (h == 10) begin
                chk("R9 frame ignored done", ndone, 0);
                chk("R9 frame ignored bytes", nb, 0);
            end else begin
                chk("R9 frame after holdoff done", ndone, 1);
                chk("R9 frame after holdoff byte", (nb == 1) ? int'(log_b[0]) : -1, 'h55);
            end
        end

        // R10: clear in the middle of a frame
        clear_log();
        sof(10);
        chr(8'h5A);
        pause(1);
        chk("R10 count before clr", int'(byte_cnt), 1);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R10 count after clr", int'(byte_cnt), 0);
        chk("R10 no done on clr", ndone, 0);
        raw(1'b1, 8);
        sof(10);
        chr(8'hC6);
        eof();
        chk("R10 frame after clr done", ndone, 1);
        chk("R10 frame after clr len", last_len, 1);

        // R11: idle cycles with a toggling line between samples
        stretch = 1'b1;
        clear_log();
        sof(12);
        chr(8'hC3); chr(8'h3C);
        eof();
        stretch = 1'b0;
        chk("R11 stretched bytes", nb, 2);
        chk("R11 stretched b0", int'(log_b[0]), 'hC3);
        chk("R11 stretched b1", int'(log_b[1]), 'h3C);
        chk("R11 stretched done", ndone, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule